// File: doc/BRIEF.md
# Timebase Transfer Target Decoder

This block sits beside a chip's time-of-day state machine and decides which core's timebase is to receive the time value, and whether a request to push that value may go ahead. Software writes a 64-bit control word to the transfer-target register. The block decodes it in one of two addressing modes and latches the result as a core index with a valid bit.

The two modes are a full register address and a short core number. In full-address mode the upper word of the data is taken as a register address. Its 12-bit register field must name the timebase receive register, and its upper 20 bits are matched against a per-core table of base addresses. In core-number mode a small core field of the data gives the index directly.

A later write to the move register is qualified against four conditions: the time-of-day machine is running, the command bit is set, a valid target is latched, and that core reports ready. If all four hold, the block pulses that core's "value sent" line for one cycle. If any one fails, it raises a one-cycle error instead. A parameter removes core-number mode for variants that support only full addresses.

Top module: `tb_xfer_target`

## Requirements
- R1: After a synchronous active-low reset, `tgt_valid`, `sent_pulse` and `err` are all zero.
- R2: On a write to offset 0x27, data bit 28 (the bit numbered 35 when counting from the MSB as 0) selects the addressing mode: set means full-address mode, clear means core-number mode.
- R3: In full-address mode the register address is `wr_data[63:32]`. Its low 12 bits (`wr_data[43:32]`) must equal 0x4A3. Any other value gives an invalid target.
- R4: In full-address mode, `wr_data[63:44]` is compared with bits 31:12 of each core's base address. The lowest-numbered matching core is selected. If no core matches, the target is invalid.
- R5: In core-number mode the index is `wr_data[36:32]`, so `wr_data[37]` is ignored. An index of `NUM_CORES` or more gives an invalid target.
- R6: With `CORE_ID_EN` = 0, a core-number-mode write always gives an invalid target.
- R7: The latched target (`tgt_valid`, `tgt_idx`) appears in the cycle after a control write. It changes only on a later control write: move writes and writes to other offsets leave it unchanged.
- R8: A write to offset 0x17 succeeds when all four conditions hold: `tod_running` is high, `wr_data[63]` is set, a valid target is latched, and `core_ready[tgt_idx]` is high. On success `sent_pulse` is one-hot on `tgt_idx` for exactly the next cycle, and `err` stays low.
- R9: A write to offset 0x17 that fails any condition of R8 raises `err` for exactly the next cycle and leaves `sent_pulse` zero.
- R10: A control write that decodes to an invalid target clears `tgt_valid` and raises `err` for exactly the next cycle. A valid decode leaves `err` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 6 | Register offset of the write |
| wr_data | input | 64 | Write data |
| core_base | input | NUM_CORES*32 | Per-core register base addresses, core 0 in the low word |
| core_ready | input | NUM_CORES | Per-core ready-to-receive flags |
| tod_running | input | 1 | Time-of-day state machine is in its running state |
| tgt_valid | output | 1 | Latched target is valid |
| tgt_idx | output | IDX_W | Latched target core index |
| sent_pulse | output | NUM_CORES | One-cycle "value sent" pulse per core |
| err | output | 1 | One-cycle error for a bad decode or a refused move |

## Verification
Full-address writes are applied in four forms:
- an exact unique base, which shows that the address field is used;
- a base shared by two cores, which shows that the lower index wins;
- a wrong register field, which is separated from a good address;
- an address that matches no core.

Core-number writes use:
- a small index;
- the same index with the ignored sixth bit set, which shows the 5-bit mask;
- an out-of-range index.

The same core-number word is also sent to a second instance built without core-number mode. Each of the four move conditions is then broken on its own, with the other three held true. This shows that every condition alone blocks the pulse.

// File: rtl/tbx_pkg.sv
// Package: constants shared by the transfer target decoder.
// Assumes 64-bit write data with bit 63 as the most significant bit.
package tbx_pkg;
    localparam int          DATA_W     = 64;
    localparam int          OFF_W      = 6;
    localparam logic [5:0]  OFF_CTRL   = 6'h27;   // transfer-target control
    localparam logic [5:0]  OFF_MOVE   = 6'h17;   // move value to timebase
    localparam logic [11:0] RX_REG     = 12'h4A3; // timebase receive register
    localparam int          MODE_BIT   = 28;      // full-address mode select
    localparam int          CMD_BIT    = 63;      // move command bit
endpackage

// File: rtl/tbx_addr_decode.sv
// Module: full-address decoder.
// Matches a 32-bit register address against a table of per-core bases and
// returns the lowest matching core. Assumes the bases' low 12 bits are don't-care.
module tbx_addr_decode #(
    parameter int NUM_CORES = 4,
    parameter int IDX_W     = 2
) (
    input  logic [31:0]             reg_addr,
    input  logic [NUM_CORES*32-1:0] core_base,
    output logic                    hit,
    output logic [IDX_W-1:0]        idx
);
    import tbx_pkg::*;

    logic [NUM_CORES-1:0] match;
    logic                 unused_base;

    // per-core compare of the upper 20 address bits
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_cmp
        assign match[c] = (reg_addr[31:12] == core_base[c*32+12 +: 20]);
    end

    // low 12 bits of each base take no part in the match
    always_comb begin
        unused_base = 1'b0;
        for (int c = 0; c < NUM_CORES; c++)
            unused_base = unused_base ^ (^core_base[c*32 +: 12]);
    end

    // lowest-index priority select, qualified by the register field
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int c = NUM_CORES - 1; c >= 0; c--) begin
            if (match[c]) begin
                hit = 1'b1;
                idx = IDX_W'(c);
            end
        end
        if (reg_addr[11:0] != RX_REG) begin
            hit = 1'b0;
            idx = '0;
        end
    end
endmodule

// File: rtl/tbx_id_decode.sv
// Module: core-number decoder.
// Takes a 5-bit core number and checks it against the core count. When
// ENABLE is 0 the mode is absent and every decode is invalid.
module tbx_id_decode #(
    parameter int NUM_CORES = 4,
    parameter int IDX_W     = 2,
    parameter bit ENABLE    = 1'b1
) (
    input  logic [4:0]       core_num,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    if (ENABLE) begin : g_on
        // range check of the core number against the core count
        assign hit = (32'(core_num) < NUM_CORES);
        assign idx = hit ? IDX_W'(core_num) : '0;
    end else begin : g_off
        logic unused_num;
        // mode removed: fixed invalid result
        assign unused_num = ^core_num;
        assign hit = 1'b0;
        assign idx = '0;
    end
endmodule

// File: rtl/tbx_move_gate.sv
// Module: move request qualifier.
// Registers a one-hot sent pulse when all four move conditions hold, and a
// one-cycle failure flag otherwise. Assumes at most one write per cycle.
module tbx_move_gate #(
    parameter int NUM_CORES = 4,
    parameter int IDX_W     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 move_wr,
    input  logic                 cmd_bit,
    input  logic                 tod_running,
    input  logic                 tgt_valid,
    input  logic [IDX_W-1:0]     tgt_idx,
    input  logic [NUM_CORES-1:0] core_ready,
    output logic [NUM_CORES-1:0] sent_q,
    output logic                 fail_q
);
    logic                 go;
    logic [NUM_CORES-1:0] onehot;

    // all four move conditions together
    assign go     = move_wr && cmd_bit && tod_running && tgt_valid && core_ready[tgt_idx];
    assign onehot = NUM_CORES'(1) << tgt_idx;

    // register the pulse or the failure for exactly one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q <= '0;
            fail_q <= 1'b0;
        end else begin
            sent_q <= go ? onehot : '0;
            fail_q <= move_wr && !go;
        end
    end

    // R8: pulse is at most one-hot
    a_r8_sent_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sent_q));
    // R8: a pulse only goes to a core that was ready
    a_r8_sent_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (|sent_q) |-> (($past(core_ready) & sent_q) == sent_q));
    // R9: a move while not running is refused
    a_r9_not_running: assert property (@(posedge clk) disable iff (!rst_n)
        (move_wr && !tod_running) |=> (sent_q == '0) && fail_q);
    // R9: pulse and failure never coincide
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !((|sent_q) && fail_q));
endmodule

// File: rtl/tb_xfer_target.sv
// Module: timebase transfer target decoder (top).
// Decodes control writes into a latched core target and qualifies move
// requests against it. Assumes a single write port with one write per cycle.
module tb_xfer_target #(
    parameter int NUM_CORES  = 4,
    parameter bit CORE_ID_EN = 1'b1,
    parameter int IDX_W      = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [5:0]              wr_off,
    input  logic [63:0]             wr_data,
    input  logic [NUM_CORES*32-1:0] core_base,
    input  logic [NUM_CORES-1:0]    core_ready,
    input  logic                    tod_running,
    output logic                    tgt_valid,
    output logic [IDX_W-1:0]        tgt_idx,
    output logic [NUM_CORES-1:0]    sent_pulse,
    output logic                    err
);
    import tbx_pkg::*;

    logic             ctrl_wr, move_wr, full_mode;
    logic             a_hit, i_hit, dec_hit;
    logic [IDX_W-1:0] a_idx, i_idx, dec_idx;
    logic             dec_err_q, move_fail_q;
    logic             unused_data;

    // write strobes by offset
    assign ctrl_wr   = wr_en && (wr_off == OFF_CTRL);
    assign move_wr   = wr_en && (wr_off == OFF_MOVE);
    assign full_mode = wr_data[MODE_BIT];
    assign unused_data = ^{wr_data[31:29], wr_data[27:0]};

    tbx_addr_decode #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_addr (
        .reg_addr (wr_data[63:32]),
        .core_base(core_base),
        .hit      (a_hit),
        .idx      (a_idx)
    );

    tbx_id_decode #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W), .ENABLE(CORE_ID_EN)) u_id (
        .core_num(wr_data[36:32]),
        .hit     (i_hit),
        .idx     (i_idx)
    );

    // pick the decode of the selected mode
    assign dec_hit = full_mode ? a_hit : i_hit;
    assign dec_idx = full_mode ? a_idx : i_idx;

    // latch the target on a control write only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_valid <= 1'b0;
            tgt_idx   <= '0;
            dec_err_q <= 1'b0;
        end else begin
            dec_err_q <= ctrl_wr && !dec_hit;
            if (ctrl_wr) begin
                tgt_valid <= dec_hit;
                tgt_idx   <= dec_idx;
            end
        end
    end

    tbx_move_gate #(.NUM_CORES(NUM_CORES), .IDX_W(IDX_W)) u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .move_wr    (move_wr),
        .cmd_bit    (wr_data[CMD_BIT]),
        .tod_running(tod_running),
        .tgt_valid  (tgt_valid),
        .tgt_idx    (tgt_idx),
        .core_ready (core_ready),
        .sent_q     (sent_pulse),
        .fail_q     (move_fail_q)
    );

    assign err = dec_err_q | move_fail_q;

    // R7: target holds without a control write
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(tgt_valid) && $stable(tgt_idx));
    // R10: good decode gives a valid target and no error
    a_r10_good: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && dec_hit) |=> tgt_valid && !err);
    // R10: bad decode clears the target and flags an error
    a_r10_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !dec_hit) |=> !tgt_valid && err);
    // R6: without core-number mode such writes never validate
    a_r6_no_id: assert property (@(posedge clk) disable iff (!rst_n)
        (!CORE_ID_EN && ctrl_wr && !full_mode) |=> !tgt_valid);
endmodule

// File: tb/tb_xfer_target_bench.sv
module tb_xfer_target_bench;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [5:0]    wr_off = '0;
    logic [63:0]   wr_data = '0;
    logic [N*32-1:0] core_base;
    logic [N-1:0]  core_ready = '0;
    logic          tod_running = 1'b0;
    logic          tgt_valid, err, nv_valid, nv_err;
    logic [1:0]    tgt_idx, nv_idx;
    logic [N-1:0]  sent_pulse, nv_sent;
    int            checks = 0, fails = 0;

    always #10 clk = ~clk;

    // bases: core1 and core3 share a base
    assign core_base = {32'h2100_0000, 32'h2200_0000, 32'h2100_0000, 32'h2000_0000};

    tb_xfer_target #(.NUM_CORES(N)) u_tb_xfer_target (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
        .core_base(core_base), .core_ready(core_ready), .tod_running(tod_running),
        .tgt_valid(tgt_valid), .tgt_idx(tgt_idx), .sent_pulse(sent_pulse), .err(err));

    tb_xfer_target #(.NUM_CORES(N), .CORE_ID_EN(1'b0)) u_tb_xfer_target_noid (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
        .core_base(core_base), .core_ready(core_ready), .tod_running(tod_running),
        .tgt_valid(nv_valid), .tgt_idx(nv_idx), .sent_pulse(nv_sent), .err(nv_err));

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one write; returns at the negedge after the capturing edge
    task automatic wr(input logic [5:0] off, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_off = off; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    function automatic logic [63:0] full_word(input logic [31:0] addr);
        return {addr, 32'h1000_0000};
    endfunction

    function automatic logic [63:0] id_word(input logic [5:0] id);
        return {26'h0, id, 32'h0};
    endfunction

    task automatic t_reset();
        check("R1 valid", 16'(tgt_valid), 16'd0);
        check("R1 sent", 16'(sent_pulse), 16'd0);
        check("R1 err", 16'(err), 16'd0);
    endtask

    task automatic t_full_addr();
        wr(6'h27, full_word(32'h2200_04A3));
        check("R2 R4 unique valid", 16'(tgt_valid), 16'd1);
        check("R4 unique idx", 16'(tgt_idx), 16'd2);
        check("R10 good no err", 16'(err), 16'd0);
        wr(6'h27, full_word(32'h2100_04A3));
        check("R4 priority idx", 16'(tgt_idx), 16'd1);
        wr(6'h27, full_word(32'h2200_04A4));
        check("R3 bad reg valid", 16'(tgt_valid), 16'd0);
        check("R10 bad reg err", 16'(err), 16'd1);
        @(negedge clk);
        check("R10 err one cycle", 16'(err), 16'd0);
        wr(6'h27, full_word(32'h2300_04A3));
        check("R4 no match valid", 16'(tgt_valid), 16'd0);
        check("R4 no match err", 16'(err), 16'd1);
    endtask

    task automatic t_core_id();
        wr(6'h27, id_word(6'd3));
        check("R5 id valid", 16'(tgt_valid), 16'd1);
        check("R5 id idx", 16'(tgt_idx), 16'd3);
        check("R6 noid invalid", 16'(nv_valid), 16'd0);
        check("R6 noid err", 16'(nv_err), 16'd1);
        wr(6'h27, id_word(6'h21));
        check("R5 mask valid", 16'(tgt_valid), 16'd1);
        check("R5 mask idx", 16'(tgt_idx), 16'd1);
        wr(6'h27, id_word(6'd5));
        check("R5 range valid", 16'(tgt_valid), 16'd0);
        check("R5 range err", 16'(err), 16'd1);
    endtask

    task automatic t_persist();
        wr(6'h27, id_word(6'd2));
        wr(6'h10, id_word(6'd0));
        check("R7 other off valid", 16'(tgt_valid), 16'd1);
        check("R7 other off idx", 16'(tgt_idx), 16'd2);
        tod_running = 1'b0;
        wr(6'h17, 64'h0);
        check("R7 after move idx", 16'(tgt_idx), 16'd2);
    endtask

    task automatic t_move();
        tod_running = 1'b1; core_ready = 4'b1111;
        wr(6'h27, id_word(6'd2));
        wr(6'h17, 64'h8000_0000_0000_0000);
        check("R8 sent", 16'(sent_pulse), 16'h4);
        check("R8 no err", 16'(err), 16'd0);
        @(negedge clk);
        check("R8 one cycle", 16'(sent_pulse), 16'd0);
        tod_running = 1'b0;
        wr(6'h17, 64'h8000_0000_0000_0000);
        check("R9 not running sent", 16'(sent_pulse), 16'd0);
        check("R9 not running err", 16'(err), 16'd1);
        tod_running = 1'b1;
        wr(6'h17, 64'h7FFF_FFFF_FFFF_FFFF);
        check("R9 cmd bit sent", 16'(sent_pulse), 16'd0);
        check("R9 cmd bit err", 16'(err), 16'd1);
        core_ready = 4'b1011;
        wr(6'h17, 64'h8000_0000_0000_0000);
        check("R9 not ready sent", 16'(sent_pulse), 16'd0);
        check("R9 not ready err", 16'(err), 16'd1);
        core_ready = 4'b1111;
        wr(6'h27, id_word(6'd7));
        wr(6'h17, 64'h8000_0000_0000_0000);
        check("R9 no target sent", 16'(sent_pulse), 16'd0);
        check("R9 no target err", 16'(err), 16'd1);
        @(negedge clk);
        check("R9 err one cycle", 16'(err), 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_addr();
        t_core_id();
        t_persist();
        t_move();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule